// File: doc/BRIEF.md
# Gated-Window Clock Frequency Meter

The block measures the frequency of one of several oscillator clocks by counting that clock's rising edges while a gate is open. The gate is opened for a fixed number of cycles of a reference clock, so the finished count reads directly as the oscillator frequency scaled by the window length. With the default 1024-cycle window and a 26 MHz reference, a clock of F MHz returns about F×1024/26.

Software drives the block through a small register port that sits in the reference domain. It chooses an oscillator and an optional pre-divisor, then writes an enable bit together with a run bit. The run bit stays set while the measurement is in progress and clears itself once the count has come back across the clock boundary. The result register is valid when the run bit reads zero. Each oscillator has its own counting lane in its own clock domain, so no clock multiplexer is needed. The gate reaches the lane through a two-flop synchronizer. A toggle that the lane returns when the gate closes tells the reference side that the frozen count can be sampled.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset every register reads zero: control (address 0), route (address 1), scale (address 2) and result (address 3).
- R2: A write to control (address 0) with bit 0 (enable) and bit 1 (run) both set, while no measurement is running, starts a measurement. Run reads 1 until the measurement completes.
- R3: The gate stays open for exactly WIN_LEN reference cycles. The result equals the number of oscillator edges in that window, within ±4 counts.
- R4: Run clears itself between WIN_LEN and WIN_LEN+20 reference cycles after the start. The result then holds its value until the next measurement completes.
- R5: A write of run without enable is ignored. Run stays 0 and the result is unchanged.
- R6: Route bits [21:16] select the oscillator. Code 0 selects oscillator 0 and code 1 selects oscillator 1. Any code of NUM_SRC or above measures nothing and returns a count of 0.
- R7: Route bits [1:0] must be 00 for a clock to reach the counter. Any other value returns a count of 0.
- R8: Scale bits [31:24] hold a pre-divisor D. Values 0 and 1 count every edge, and D≥2 counts one per D edges.
- R9: A control write with enable clear aborts a running measurement. Run reads 0 on the next cycle, the result keeps its previous value, and later measurements work normally.
- R10: The edge count saturates at its all-ones value (2^CNT_W−1) and does not wrap.
- R11: Route reads back only bits [21:16] and [1:0], scale only bits [31:24], and control only bits [1:0]. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock that times the gate window and the register port |
| rst_ni | input | 1 | Synchronous active-low reset, reference domain |
| osc_clk_i | input | NUM_SRC | Oscillator clocks that can be measured |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Combinational read data for rd_addr_i |

## Verification
Register reads are combinational, so the bench sets the read address on a falling edge and samples 1 ns later. Each write registers on the next rising edge and can be read back on the falling edge that follows. A measurement's result is due only after the window plus the synchronizer and toggle latency, which is a few oscillator and reference cycles. The bench therefore polls the run bit once per reference cycle, checks that it falls inside the R4 cycle bracket, and reads the result only after that. Counts are compared against ranges computed from the bench clock periods, which covers the one-edge uncertainty at each end of the gate. The saturation case runs a second instance with an 8-bit counter side by side with the first.

// File: rtl/fm_pkg.sv
// Package: shared types and register layout for the clock frequency meter.
// Assumes a 2-bit register address and a 32-bit data word.
package fm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_DRAIN = 2'd2
    } fm_state_e;

    localparam logic [1:0] REG_CTRL   = 2'd0;
    localparam logic [1:0] REG_ROUTE  = 2'd1;
    localparam logic [1:0] REG_SCALE  = 2'd2;
    localparam logic [1:0] REG_RESULT = 2'd3;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_RUN_BIT = 1;
    localparam int MODE_LSB     = 0;
    localparam int MODE_W       = 2;
    localparam int SRC_LSB      = 16;
    localparam int SRC_W        = 6;
    localparam int DIV_LSB      = 24;
    localparam int DIV_W        = 8;

endpackage

// File: rtl/fm_sync.sv
// Module: multi-stage flip-flop synchronizer for a single bit.
// Assumes the input is a level or a toggle that is held for several
// destination cycles. STAGES must be at least 2.
module fm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/fm_lane.sv
// Module: per-oscillator counting lane, clocked by the oscillator itself.
// Counts pre-divided edges while the synchronized gate is high, clears on
// the gate's rising edge and flips a toggle when the gate falls. After the
// toggle the count stays frozen until the next gate. Assumes div_i is
// stable from before the gate opens until the toggle returns.
module fm_lane #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_tgl_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             lane_rst_n;
    logic             gate_s;
    logic             gate_d;
    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] pre_lim;
    logic [CNT_W-1:0] cnt_q;
    logic             tgl_q;

    // Bring the reference-domain reset into the oscillator domain.
    fm_sync #(.STAGES(2)) u_rst_sync (
        .clk   (osc_clk),
        .rst_n (1'b1),
        .d_i   (rst_n),
        .q_o   (lane_rst_n)
    );

    // Bring the gate level into the oscillator domain.
    fm_sync #(.STAGES(2)) u_gate_sync (
        .clk   (osc_clk),
        .rst_n (lane_rst_n),
        .d_i   (gate_i),
        .q_o   (gate_s)
    );

    // Last pre-divider value before a count step; 0 and 1 both mean no division.
    assign pre_lim = (div_i == '0) ? '0 : div_i - 1'b1;

    // Count edges inside the gate, saturating, and signal gate closure.
    always_ff @(posedge osc_clk) begin
        if (!lane_rst_n) begin
            gate_d <= 1'b0;
            pre_q  <= '0;
            cnt_q  <= '0;
            tgl_q  <= 1'b0;
        end else begin
            gate_d <= gate_s;
            if (gate_s && !gate_d) begin
                pre_q <= '0;
                cnt_q <= '0;
            end else if (gate_s) begin
                if (pre_q == pre_lim) begin
                    pre_q <= '0;
                    if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
            if (!gate_s && gate_d) tgl_q <= ~tgl_q;
        end
    end

    assign cnt_o      = cnt_q;
    assign done_tgl_o = tgl_q;

endmodule

// File: rtl/fm_ctrl.sv
// Module: reference-domain sequencer of the frequency meter.
// Opens a one-hot gate toward the chosen lane for exactly WIN_LEN cycles,
// then waits for that lane's toggle and reports the frozen count. If the
// route is not valid, the window still runs and a zero count is reported.
// Assumes start_i and abort_i are single-cycle pulses and never both high.
module fm_ctrl #(
    parameter int NUM_SRC = 2,
    parameter int WIN_LEN = 1024,
    parameter int CNT_W   = 16,
    parameter int DIV_W   = 8,
    localparam int SEL_W  = $clog2(NUM_SRC),
    localparam int WIN_W  = $clog2(WIN_LEN)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic                            abort_i,
    input  logic                            route_ok_i,
    input  logic [SEL_W-1:0]                sel_i,
    input  logic [DIV_W-1:0]                div_i,
    input  logic [NUM_SRC-1:0][CNT_W-1:0]   lane_cnt_i,
    input  logic [NUM_SRC-1:0]              lane_tgl_i,
    output logic [NUM_SRC-1:0]              gate_o,
    output logic [DIV_W-1:0]                div_o,
    output logic                            cap_o,
    output logic [CNT_W-1:0]                cap_val_o
);

    import fm_pkg::*;

    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

    fm_state_e          state_q;
    logic [WIN_W-1:0]   win_q;
    logic [SEL_W-1:0]   sel_q;
    logic               ok_q;
    logic [DIV_W-1:0]   div_q;
    logic [NUM_SRC-1:0] gate_q;
    logic [NUM_SRC-1:0] tgl_s;
    logic [NUM_SRC-1:0] tgl_d;
    logic [NUM_SRC-1:0] tgl_edge;
    logic               win_end;

    // One toggle synchronizer per lane.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_tgl_sync
        fm_sync #(.STAGES(2)) u_tgl_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (lane_tgl_i[i]),
            .q_o   (tgl_s[i])
        );
    end

    // Remember the last synchronized toggles so stale flips are consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) tgl_d <= '0;
        else        tgl_d <= tgl_s;
    end

    assign tgl_edge = tgl_s ^ tgl_d;
    assign win_end  = (state_q == ST_GATE) && (win_q == WIN_LAST);

    // Sequence: idle, open gate for the window, drain the lane's count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
            sel_q   <= '0;
            ok_q    <= 1'b0;
            div_q   <= '0;
            gate_q  <= '0;
        end else if (abort_i) begin
            state_q <= ST_IDLE;
            gate_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_GATE;
                    win_q   <= '0;
                    sel_q   <= sel_i;
                    ok_q    <= route_ok_i;
                    div_q   <= div_i;
                    gate_q  <= route_ok_i ? (NUM_SRC'(1) << sel_i) : '0;
                end
                ST_GATE: begin
                    win_q <= win_q + 1'b1;
                    if (win_end) begin
                        gate_q  <= '0;
                        state_q <= ok_q ? ST_DRAIN : ST_IDLE;
                    end
                end
                ST_DRAIN: if (tgl_edge[sel_q]) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign gate_o    = gate_q;
    assign div_o     = div_q;
    assign cap_o     = (win_end && !ok_q) ||
                       ((state_q == ST_DRAIN) && tgl_edge[sel_q]);
    assign cap_val_o = ok_q ? lane_cnt_i[sel_q] : '0;

endmodule

// File: rtl/clk_freq_meter.sv
// Module: top of the gated-window clock frequency meter.
// Holds the software registers in the reference domain, decodes start and
// abort, instantiates one counting lane per oscillator and the sequencer.
// Assumes NUM_SRC >= 2, CNT_W < 32 and a free-running reference clock.
module clk_freq_meter #(
    parameter int NUM_SRC = 2,
    parameter int WIN_LEN = 1024,
    parameter int CNT_W   = 16
) (
    input  logic               clk_ref_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] osc_clk_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [31:0]        wr_data_i,
    input  logic [1:0]         rd_addr_i,
    output logic [31:0]        rd_data_o
);

    import fm_pkg::*;

    localparam int SEL_W = $clog2(NUM_SRC);

    logic                          en_q;
    logic                          run_q;
    logic [MODE_W-1:0]             mode_q;
    logic [SRC_W-1:0]              src_q;
    logic [DIV_W-1:0]              div_q;
    logic [CNT_W-1:0]              result_q;
    logic                          ctrl_wr;
    logic                          start;
    logic                          abort;
    logic                          route_ok;
    logic [NUM_SRC-1:0]            gate_vec;
    logic [DIV_W-1:0]              lane_div;
    logic [NUM_SRC-1:0][CNT_W-1:0] lane_cnt;
    logic [NUM_SRC-1:0]            lane_tgl;
    logic                          cap;
    logic [CNT_W-1:0]              cap_val;

    assign ctrl_wr  = wr_en_i && (wr_addr_i == REG_CTRL);
    assign start    = ctrl_wr && wr_data_i[CTRL_EN_BIT] &&
                      wr_data_i[CTRL_RUN_BIT] && !run_q;
    assign abort    = ctrl_wr && !wr_data_i[CTRL_EN_BIT] && run_q;
    assign route_ok = (mode_q == '0) && (src_q < SRC_W'(NUM_SRC));

    // Configuration registers written from the register port.
    always_ff @(posedge clk_ref_i) begin
        if (!rst_ni) begin
            en_q   <= 1'b0;
            mode_q <= '0;
            src_q  <= '0;
            div_q  <= '0;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                REG_CTRL:  en_q <= wr_data_i[CTRL_EN_BIT];
                REG_ROUTE: begin
                    mode_q <= wr_data_i[MODE_LSB +: MODE_W];
                    src_q  <= wr_data_i[SRC_LSB +: SRC_W];
                end
                REG_SCALE: div_q <= wr_data_i[DIV_LSB +: DIV_W];
                default: ;
            endcase
        end
    end

    // Self-clearing run bit and result capture.
    always_ff @(posedge clk_ref_i) begin
        if (!rst_ni) begin
            run_q    <= 1'b0;
            result_q <= '0;
        end else if (abort || (ctrl_wr && !wr_data_i[CTRL_EN_BIT])) begin
            run_q <= 1'b0;
        end else if (start) begin
            run_q <= 1'b1;
        end else if (cap && run_q) begin
            run_q    <= 1'b0;
            result_q <= cap_val;
        end
    end

    fm_ctrl #(
        .NUM_SRC (NUM_SRC),
        .WIN_LEN (WIN_LEN),
        .CNT_W   (CNT_W),
        .DIV_W   (DIV_W)
    ) u_ctrl (
        .clk        (clk_ref_i),
        .rst_n      (rst_ni),
        .start_i    (start),
        .abort_i    (abort),
        .route_ok_i (route_ok),
        .sel_i      (src_q[SEL_W-1:0]),
        .div_i      (div_q),
        .lane_cnt_i (lane_cnt),
        .lane_tgl_i (lane_tgl),
        .gate_o     (gate_vec),
        .div_o      (lane_div),
        .cap_o      (cap),
        .cap_val_o  (cap_val)
    );

    // One counting lane per oscillator, each in its own clock domain.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        fm_lane #(
            .CNT_W (CNT_W),
            .DIV_W (DIV_W)
        ) u_lane (
            .osc_clk    (osc_clk_i[i]),
            .rst_n      (rst_ni),
            .gate_i     (gate_vec[i]),
            .div_i      (lane_div),
            .cnt_o      (lane_cnt[i]),
            .done_tgl_o (lane_tgl[i])
        );
    end

    // Read-data multiplexer.
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            REG_CTRL: begin
                rd_data_o[CTRL_EN_BIT]  = en_q;
                rd_data_o[CTRL_RUN_BIT] = run_q;
            end
            REG_ROUTE: begin
                rd_data_o[MODE_LSB +: MODE_W] = mode_q;
                rd_data_o[SRC_LSB +: SRC_W]   = src_q;
            end
            REG_SCALE:  rd_data_o[DIV_LSB +: DIV_W] = div_q;
            REG_RESULT: rd_data_o[CNT_W-1:0] = result_q;
            default: ;
        endcase
    end

endmodule

// File: rtl/clk_freq_meter_chk.sv
// Module: assertion checker for clk_freq_meter, attached through bind.
// Observes register-port inputs and internal state of the top module.
module clk_freq_meter_chk #(
    parameter int NUM_SRC = 2,
    parameter int WIN_LEN = 1024,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               run,
    input logic [CNT_W-1:0]   result,
    input logic [NUM_SRC-1:0] gate,
    input logic               wr_en,
    input logic [1:0]         wr_addr,
    input logic [31:0]        wr_data
);

    localparam int OPEN_W = $clog2(WIN_LEN) + 2;

    logic              gate_any;
    logic              abort_wr;
    logic [OPEN_W-1:0] open_cnt;

    assign gate_any = |gate;
    assign abort_wr = wr_en && (wr_addr == 2'd0) && !wr_data[0];

    // Count how many cycles the gate has been open.
    always_ff @(posedge clk) begin
        if (!rst_n)        open_cnt <= '0;
        else if (gate_any) open_cnt <= open_cnt + 1'b1;
        else               open_cnt <= '0;
    end

    assert_run_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> en);

    assert_start_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(wr_en && wr_addr == 2'd0 && wr_data[0] && wr_data[1]));

    assert_result_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(result));

    assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_wr |=> !run);

    assert_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate));

    assert_window_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_any) && !$past(abort_wr)) |-> (open_cnt == OPEN_W'(WIN_LEN)));

endmodule

bind clk_freq_meter clk_freq_meter_chk #(
    .NUM_SRC (NUM_SRC),
    .WIN_LEN (WIN_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk     (clk_ref_i),
    .rst_n   (rst_ni),
    .en      (en_q),
    .run     (run_q),
    .result  (result_q),
    .gate    (gate_vec),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i)
);

// File: tb/clk_freq_meter_bench.sv
// Bench: self-checking testbench for clk_freq_meter. Reference clock is
// 10 ns, oscillator 0 is 4 ns, oscillator 1 is 14 ns. A second instance
// with an 8-bit counter shares the inputs for the saturation case.
module clk_freq_meter_bench;

    localparam int WIN = 1024;
    localparam int NV  = 8;

    // Vector fields: src[47:42] mode[41:40] div[39:32] lo[31:16] hi[15:0]
    localparam logic [47:0] VECS [NV] = '{
        {6'd0,  2'd0, 8'd0, 16'd2556, 16'd2564},  // R3 R6 osc0 undivided
        {6'd1,  2'd0, 8'd0, 16'd727,  16'd736},   // R6 osc1 undivided
        {6'd0,  2'd0, 8'd4, 16'd636,  16'd644},   // R8 divide by 4
        {6'd0,  2'd0, 8'd1, 16'd2556, 16'd2564},  // R8 divisor 1 = none
        {6'd1,  2'd0, 8'd3, 16'd240,  16'd248},   // R8 divide by 3
        {6'd5,  2'd0, 8'd0, 16'd0,    16'd0},     // R6 unmapped code
        {6'd63, 2'd0, 8'd0, 16'd0,    16'd0},     // R6 top code
        {6'd0,  2'd2, 8'd0, 16'd0,    16'd0}      // R7 mode not 00
    };

    logic        clk = 1'b0;
    logic        osc0 = 1'b0;
    logic        osc1 = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] rd_data_sat;
    logic [1:0]  osc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    assign osc = {osc1, osc0};

    always #5 clk  = ~clk;
    always #2 osc0 = ~osc0;
    always #7 osc1 = ~osc1;

    clk_freq_meter u_clk_freq_meter (
        .clk_ref_i (clk),
        .rst_ni    (rst_n),
        .osc_clk_i (osc),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    clk_freq_meter #(.CNT_W(8)) u_clk_freq_meter_sat (
        .clk_ref_i (clk),
        .rst_ni    (rst_n),
        .osc_clk_i (osc),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data_sat)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(input string req, input longint act,
                       input longint lo, input longint hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // Start a measurement and return the cycles until run clears.
    task automatic measure(input logic [5:0] src, input logic [1:0] mode,
                           input logic [7:0] div, output int cyc);
        logic [31:0] v;
        wr(2'd1, {10'd0, src, 14'd0, mode});
        wr(2'd2, {div, 24'd0});
        wr(2'd0, 32'd3);
        cyc = -1;
        for (int n = 0; n < WIN + 200; n++) begin
            rd(2'd0, v);
            if (!v[1]) begin
                cyc = n;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] prev;
        int cyc;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset value", v, 0, 0);
        end

        // R11: readback masks
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R11 route mask", v, 32'h003F_0003, 32'h003F_0003);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R11 scale mask", v, 32'hFF00_0000, 32'hFF00_0000);
        wr(2'd0, 32'hFFFF_FFFC);
        rd(2'd0, v); chk("R11 ctrl mask", v, 0, 0);

        // Vector table: route, divisor and count range
        for (int i = 0; i < NV; i++) begin
            measure(VECS[i][47:42], VECS[i][41:40], VECS[i][39:32], cyc);
            chk("R4 run self-clear timing", cyc, WIN, WIN + 20);
            rd(2'd3, v);
            chk("R3 R6 R7 R8 count", v, VECS[i][31:16], VECS[i][15:0]);
            if (i == 0) begin
                // R10: 8-bit instance saturates on 2560 edges
                chk("R10 saturation", rd_data_sat, 255, 255);
            end
            if (i == 4) begin
                // R10: no saturation below the limit
                chk("R10 below limit", rd_data_sat, 240, 248);
            end
        end

        // R2 and R9: run high mid-window, then abort
        rd(2'd3, prev);
        wr(2'd1, {10'd0, 6'd1, 16'd0});
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd3);
        repeat (500) @(negedge clk);
        rd(2'd0, v); chk("R2 run busy", v, 3, 3);
        wr(2'd0, 32'd0);
        rd(2'd0, v); chk("R9 abort clears run", v, 0, 0);
        rd(2'd3, v); chk("R9 result kept", v, prev, prev);
        repeat (1200) @(negedge clk);
        rd(2'd3, v); chk("R9 result kept later", v, prev, prev);

        // R5: run without enable ignored
        wr(2'd0, 32'd2);
        rd(2'd0, v); chk("R5 run ignored", v, 0, 0);
        repeat (1200) @(negedge clk);
        rd(2'd3, v); chk("R5 R4 result unchanged", v, prev, prev);

        // R9: measurement works after an abort
        measure(6'd0, 2'd0, 8'd0, cyc);
        chk("R9 R4 timing after abort", cyc, WIN, WIN + 20);
        rd(2'd3, v); chk("R9 R3 count after abort", v, 2556, 2564);

        finish_run();
    end

endmodule